// File: doc/BRIEF.md
# Edge-Capturing Key Interrupt Controller

This block watches a group of key input pins and raises a single interrupt request whenever an enabled pin shows the edge chosen for it. Each pin has its own enable bit and its own polarity bit. The polarity bit selects the rising or the falling edge. Every valid edge is latched into a per-pin event bit. The event bit stays set after the pin goes back to its old level, so software can find the source of an interrupt later.

Software reaches the block through a small synchronous register bus with four byte registers: enable mask, polarity select, event capture and control. Reading the event register hands back the captured bits and clears exactly those bits. An edge that arrives in the same cycle as the read is kept. Any write to the event register empties it. The interrupt request is a sticky flag. A write of 1 to bit 0 of the control register clears it. After software changes the enable or polarity settings, it can discard stale state with a dummy write to the event register followed by a request clear.

Top module: `keyint_ctrl`

## Requirements
- R1: Under synchronous reset, the enable, polarity and event registers become 0x00, the request flag becomes 0 and read data becomes 0x00.
- R2: Register addresses are 0 = enable mask, 1 = polarity select, 2 = event capture, 3 = control. A written enable or polarity value reads back unchanged. Read data appears in the cycle after the read strobe and holds until the next read.
- R3: Polarity bit 0 makes the falling edge valid for that pin and polarity bit 1 makes the rising edge valid. The opposite edge has no effect.
- R4: A valid edge on an enabled pin sets that pin's event bit (bit i for pin i). The bit is visible after the third rising clock edge that follows the pin change (two synchroniser flops plus one edge-history flop). It stays set when the pin returns to its former level.
- R5: A pin whose enable bit is 0 never sets its event bit and never sets the request flag.
- R6: A read of the event register returns its value and clears every bit that was returned as 1, in the same cycle that the read data becomes valid.
- R7: If a valid edge on a pin is detected in the same cycle that a read clears that pin's event bit, the bit stays 1.
- R8: Any write to the event register clears all event bits, whatever the write data. An edge detected in that same cycle is still recorded.
- R9: The request flag is set in any cycle in which an enabled pin has a valid edge. It stays set until a write to the control register with data bit 0 = 1. A control write with bit 0 = 0 leaves the flag unchanged.
- R10: When a request set and a request clear fall in the same cycle, the flag ends up 1.
- R11: A read of the control register returns the request flag in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_i | input | 8 | Asynchronous key pins |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
Two pairs of actions can meet in one cycle. The first pair is a clear-on-read of the event register and a newly detected edge on the same pin. The second pair is a request-clear write and a request set. The bench changes a pin and then counts three clock edges through the synchroniser and the edge-history flop, so that the read strobe or the control write lands in the exact cycle the edge is detected. It then checks that the read returned the old value while the pin's event bit survived, and that the request flag stayed high despite the clear.

// File: rtl/keyint_pkg.sv
package keyint_pkg;

    localparam int KEY_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 2'd0,
        REG_POLAR  = 2'd1,
        REG_EVENT  = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    localparam int CTRL_CLR_BIT = 0;

    typedef struct packed {
        logic                 wr;
        logic                 rd;
        logic [ADDR_W-1:0]    addr;
        logic [KEY_W-1:0]     wdata;
    } bus_req_t;

    typedef struct packed {
        logic ev_rd;
        logic ev_wr;
        logic irq_clr;
    } ev_ctl_t;

    // Per-bit pick of rising or falling qualifier by polarity.
    function automatic logic [KEY_W-1:0] pick_edge(
        input logic [KEY_W-1:0] rise,
        input logic [KEY_W-1:0] fall,
        input logic [KEY_W-1:0] pol
    );
        return (rise & pol) | (fall & ~pol);
    endfunction

endpackage

// File: rtl/keyint_sync.sv
module keyint_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    localparam int LAST = STAGES - 1;

    for (genvar p = 0; p < W; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              hist_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
                hist_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[p]};
                hist_q  <= chain_q[LAST];
            end
        end

        assign lvl_o[p]  = chain_q[LAST];
        assign prev_o[p] = hist_q;
    end
endmodule

// File: rtl/keyint_detect.sv
module keyint_detect
    import keyint_pkg::*;
(
    input  logic [KEY_W-1:0] lvl_i,
    input  logic [KEY_W-1:0] prev_i,
    input  logic [KEY_W-1:0] pol_i,
    input  logic [KEY_W-1:0] en_i,
    output logic [KEY_W-1:0] hit_o,
    output logic             hit_any_o
);
    logic [KEY_W-1:0] rise, fall;

    always_comb begin
        rise      = lvl_i & ~prev_i;
        fall      = ~lvl_i & prev_i;
        hit_o     = pick_edge(rise, fall, pol_i) & en_i;
        hit_any_o = |hit_o;
    end
endmodule

// File: rtl/keyint_event.sv
module keyint_event
    import keyint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] hit_i,
    input  ev_ctl_t          ctl_i,
    output logic [KEY_W-1:0] ev_o
);
    logic [KEY_W-1:0] ev_q, drop_mask, ev_d;

    always_comb begin
        // Bits handed out by a read are dropped; a write drops all.
        drop_mask = '0;
        if (ctl_i.ev_rd)
            drop_mask = ev_q;
        if (ctl_i.ev_wr)
            drop_mask = '1;
        ev_d = (ev_q & ~drop_mask) | hit_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ev_q <= '0;
        else
            ev_q <= ev_d;
    end

    assign ev_o = ev_q;
endmodule

// File: rtl/keyint_regfile.sv
module keyint_regfile
    import keyint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req_i,
    input  logic [KEY_W-1:0] ev_i,
    input  logic             hit_any_i,
    output logic [KEY_W-1:0] en_o,
    output logic [KEY_W-1:0] pol_o,
    output logic             irq_o,
    output ev_ctl_t          ctl_o,
    output logic [KEY_W-1:0] rdata_o
);
    logic [KEY_W-1:0] en_q, pol_q, rdata_q, rmux;
    logic             irq_q;
    reg_sel_e         sel;

    always_comb begin
        sel           = reg_sel_e'(req_i.addr);
        ctl_o.ev_rd   = req_i.rd && sel == REG_EVENT;
        ctl_o.ev_wr   = req_i.wr && sel == REG_EVENT;
        ctl_o.irq_clr = req_i.wr && sel == REG_CTRL && req_i.wdata[CTRL_CLR_BIT];
        unique case (sel)
            REG_ENABLE: rmux = en_q;
            REG_POLAR:  rmux = pol_q;
            REG_EVENT:  rmux = ev_i;
            default:    rmux = {{(KEY_W-1){1'b0}}, irq_q};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            pol_q   <= '0;
            irq_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (req_i.wr && sel == REG_ENABLE)
                en_q <= req_i.wdata;
            if (req_i.wr && sel == REG_POLAR)
                pol_q <= req_i.wdata;
            // Set takes precedence over clear.
            if (hit_any_i)
                irq_q <= 1'b1;
            else if (ctl_o.irq_clr)
                irq_q <= 1'b0;
            if (req_i.rd)
                rdata_q <= rmux;
        end
    end

    assign en_o    = en_q;
    assign pol_o   = pol_q;
    assign irq_o   = irq_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/keyint_ctrl.sv
module keyint_ctrl
    import keyint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [KEY_W-1:0]  wdata_i,
    output logic [KEY_W-1:0]  rdata_o,
    output logic              irq_o
);
    bus_req_t         req;
    ev_ctl_t          ctl;
    logic [KEY_W-1:0] lvl, prev, hit, ev, en, pol;
    logic             hit_any;

    assign req = '{wr: wr_i, rd: rd_i, addr: addr_i, wdata: wdata_i};

    keyint_sync #(.W(KEY_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (key_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    keyint_detect u_detect (
        .lvl_i     (lvl),
        .prev_i    (prev),
        .pol_i     (pol),
        .en_i      (en),
        .hit_o     (hit),
        .hit_any_o (hit_any)
    );

    keyint_event u_event (
        .clk   (clk),
        .rst   (rst),
        .hit_i (hit),
        .ctl_i (ctl),
        .ev_o  (ev)
    );

    keyint_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .ev_i      (ev),
        .hit_any_i (hit_any),
        .en_o      (en),
        .pol_o     (pol),
        .irq_o     (irq_o),
        .ctl_o     (ctl),
        .rdata_o   (rdata_o)
    );
endmodule

// File: rtl/keyint_ctrl_chk.sv
module keyint_ctrl_chk
    import keyint_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic [KEY_W-1:0]  wdata_i,
    input logic [KEY_W-1:0]  rdata_o,
    input logic              irq_o,
    input logic [KEY_W-1:0]  hit,
    input logic [KEY_W-1:0]  ev,
    input logic [KEY_W-1:0]  en
);
    assert_rst_clean_R1: assert property (@(posedge clk)
        rst |=> (ev == '0 && !irq_o && rdata_o == '0 && en == '0));

    assert_read_snapshot_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == REG_EVENT) |=> rdata_o == $past(ev));

    assert_edge_survives_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == REG_EVENT && hit != '0) |=> ((ev & $past(hit)) == $past(hit)));

    assert_write_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == REG_EVENT) |=> ev == $past(hit));

    assert_no_disabled_event_R5: assert property (@(posedge clk) disable iff (rst)
        (hit & ~en) == '0);

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !(wr_i && addr_i == REG_CTRL && wdata_i[CTRL_CLR_BIT])) |=> irq_o);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> irq_o);

    assert_event_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!rd_i && !wr_i) |=> ((ev & $past(ev)) == $past(ev)));
endmodule

bind keyint_ctrl keyint_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .hit     (hit),
    .ev      (ev),
    .en      (en)
);

// File: tb/keyint_ctrl_test.sv
`timescale 1ns/1ps
module keyint_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] key = 8'h00;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    int         n_chk = 0, n_bad = 0;
    logic [7:0] got;

    always #5 clk = ~clk;

    keyint_ctrl uut (
        .clk(clk), .rst(rst), .key_i(key), .addr_i(addr), .wr_i(wr),
        .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    localparam logic [1:0] A_EN = 2'd0, A_POL = 2'd1, A_EV = 2'd2, A_CTL = 2'd3;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    // Drive pins, then wait until the capture edge (third posedge) has passed.
    task automatic drive_key(input logic [7:0] v);
        @(negedge clk); key = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 irq", {7'b0, irq}, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        bus_rd(A_EN, got);  check("R1 enable", got, 8'h00);
        bus_rd(A_POL, got); check("R1 polarity", got, 8'h00);
        bus_rd(A_EV, got);  check("R1 event", got, 8'h00);
        bus_rd(A_CTL, got); check("R1 ctrl", got, 8'h00);
    endtask

    task automatic t_regs;
        bus_wr(A_EN, 8'hA5);  bus_rd(A_EN, got);  check("R2 enable rb", got, 8'hA5);
        bus_wr(A_POL, 8'h3C); bus_rd(A_POL, got); check("R2 polarity rb", got, 8'h3C);
        @(negedge clk); check("R2 rdata holds", rdata, 8'h3C);
        bus_wr(A_EN, 8'hFF); bus_wr(A_POL, 8'h0F);
    endtask

    task automatic t_rise_fall;
        drive_key(8'h01);
        check("R9 irq set", {7'b0, irq}, 8'h01);
        bus_rd(A_CTL, got); check("R11 ctrl irq bit", got, 8'h01);
        drive_key(8'h00);  // falling on rising-polarity pin: ignored, bit kept
        bus_rd(A_EV, got); check("R4 sticky event", got, 8'h01);
        bus_rd(A_EV, got); check("R6 cleared by read", got, 8'h00);
        bus_wr(A_CTL, 8'h00); check("R9 ctrl bit0=0 no clear", {7'b0, irq}, 8'h01);
        bus_wr(A_CTL, 8'h01); check("R9 irq cleared", {7'b0, irq}, 8'h00);
        drive_key(8'h10);  // rising on falling-polarity pin 4: ignored
        bus_rd(A_EV, got); check("R3 rising ignored", got, 8'h00);
        check("R3 no irq", {7'b0, irq}, 8'h00);
        drive_key(8'h00);
        bus_rd(A_EV, got); check("R3 falling captured", got, 8'h10);
        bus_wr(A_CTL, 8'h01);
    endtask

    task automatic t_disabled;
        bus_wr(A_EN, 8'h0F);
        drive_key(8'h20);
        drive_key(8'h00);
        bus_rd(A_EV, got); check("R5 disabled no event", got, 8'h00);
        check("R5 disabled no irq", {7'b0, irq}, 8'h00);
        bus_wr(A_EN, 8'hFF);
    endtask

    task automatic t_write_clear;
        drive_key(8'h01);
        bus_wr(A_EV, 8'h00);
        bus_rd(A_EV, got); check("R8 write 00 clears", got, 8'h00);
        drive_key(8'h03);
        bus_wr(A_EV, 8'hFF);
        bus_rd(A_EV, got); check("R8 write FF clears", got, 8'h00);
        bus_wr(A_CTL, 8'h01);
    endtask

    task automatic t_read_race;
        drive_key(8'h07);  // pin 2 rising -> event 0x04
        @(negedge clk); key = 8'h0F;  // pin 3 rising, detected at third posedge
        @(negedge clk);
        @(negedge clk); addr = A_EV; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        check("R6 read returns old", rdata, 8'h04);
        bus_rd(A_EV, got); check("R7 edge survives read", got, 8'h08);
        bus_rd(A_EV, got); check("R6 now empty", got, 8'h00);
    endtask

    task automatic t_irq_race;
        bus_wr(A_CTL, 8'h01);
        drive_key(8'h0E);  // pin 0 falling, polarity rising: ignored
        check("R3 irq idle", {7'b0, irq}, 8'h00);
        @(negedge clk); key = 8'h0F;
        @(negedge clk);
        @(negedge clk); addr = A_CTL; wdata = 8'h01; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        check("R10 set wins over clear", {7'b0, irq}, 8'h01);
        bus_wr(A_CTL, 8'h01);
        check("R9 clear after race", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_regs;
        t_rise_fall;
        t_disabled;
        t_write_clear;
        t_read_race;
        t_irq_race;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule